// File: doc/BRIEF.md
# Card Command Line Sequencer

This block runs the command half of an SD/MMC card transaction. Software first writes a 32-bit argument word and then a command word. The command word holds a 6-bit opcode and three control bits. Setting the enable bit makes the block build a 48-bit command frame and shift it out on the command line, most significant bit first. The frame carries a CRC7 trailer.

Once the frame is sent, the block either finishes at once or listens on the same line for a reply. A reply is either a short 48-bit response or a long 136-bit response. If the reply never begins, the block gives up after a fixed window. Results go into four 32-bit response words and four sticky status flags. Software clears each flag by writing a one to its bit position in the clear register.

All activity on the line advances only on an external card-clock enable strobe. Register writes take effect on the system clock. The line is split into a driven value, an output enable and a sampled input, so the pad can be tri-stated outside the block.

Top module: `sdcmd_seq`

## Requirements
- R1: The register addresses on `wr_addr` are 0 for the argument, 1 for the command and 2 for the status clear. A command write with bit 8 (enable) set drives a 48-bit frame, one bit per `clk_en` strobe, MSB first. The frame is: a 0, a 1, opcode = command bits [5:0], the 32-bit argument, CRC7 (x^7+x^3+1, zero seed) over those first 40 bits, and a final 1. `cmd_oe` is high only while the frame is on the line, and `cmd_o` idles at 1.
- R2: Command bit 6 requests a response. Without it, the strobe carrying the end bit sets status bit 3 (sent). With it, a good response sets status bit 2 (response end) and never sets bit 3.
- R3: Command bit 7 selects a long reply. A long reply is 136 bits: `resp0` gets the first 32 bits after the 8 header bits, then `resp1`, `resp2` and `resp3` follow, with `resp3` ending in the end bit. A short reply is 48 bits: bits [39:8] go into `resp0`, and `resp1`..`resp3` keep their values. Response words change only when a reply completes.
- R4: After the end bit, a 0 seen on `cmd_i` at one of the next 64 strobes starts the reply. If `cmd_i` is still 1 at the 64th strobe, status bit 1 (timeout) is set and the block goes idle.
- R5: For a short reply, the block computes the CRC7 over the first 40 received bits and compares it with the next 7 bits. On a mismatch it sets status bit 0 (CRC fail) instead of bit 2. A long reply is never CRC-checked.
- R6: A command write with bit 8 clear returns the block to idle within one system clock. It releases the line and abandons the frame or reply, and no completion flag is set for that command. This holds even when the write coincides with the last strobe.
- R7: Status bits stay set until a clear write has a 1 in their position. Clear bits that are 0 leave their flags untouched.
- R8: When a flag is set and cleared in the same cycle, the set wins.
- R9: Without `clk_en` strobes, the line and the sequence do not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Card-clock strobe; one line bit per strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 argument, 1 command, 2 status clear |
| wr_data | input | 32 | Write data |
| cmd_i | input | 1 | Sampled command line |
| cmd_o | output | 1 | Value driven on the command line |
| cmd_oe | output | 1 | Drive enable for the command line |
| busy | output | 1 | High while a command or reply is in progress |
| status | output | 4 | Sticky flags: [3] sent, [2] response end, [1] timeout, [0] CRC fail |
| resp0 | output | 32 | First response word |
| resp1 | output | 32 | Second response word |
| resp2 | output | 32 | Third response word |
| resp3 | output | 32 | Fourth response word |

## Verification
A software write can land in the same system-clock cycle as the strobe that completes a command. Two cases matter here. The first is a status-clear write against the setting of the sent flag. The bench places the write in the exact cycle of the 48th strobe and expects the sent flag to survive. The second is an abort write in that same cycle. There the bench expects the block idle with no flag at all, and it judges both cases by reading `status` and `busy` after the edge.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int OPC_W     = 6;
  localparam int ARG_W     = 32;
  localparam int CRC_W     = 7;
  localparam int FRAME_W   = 48;
  localparam int LONG_W    = 136;
  localparam int WORD_W    = 32;
  localparam int RSP_WORDS = 4;
  localparam int STAT_W    = 4;
  localparam int HDR_W     = 2 + OPC_W;
  localparam int BODY_W    = HDR_W + ARG_W;

  localparam int CMDB_RESP = 6;
  localparam int CMDB_LONG = 7;
  localparam int CMDB_EN   = 8;

  localparam int ST_CRCFAIL = 0;
  localparam int ST_TIMEOUT = 1;
  localparam int ST_RSPEND  = 2;
  localparam int ST_SENT    = 3;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_TX, SEQ_RX} seq_state_t;
  typedef enum logic [1:0] {ADR_ARG = 2'd0, ADR_CMD = 2'd1, ADR_CLR = 2'd2} reg_addr_t;

  function automatic logic [CRC_W-1:0] crc7_body(input logic [BODY_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = BODY_W - 1; i >= 0; i--) begin
      fb = d[i] ^ c[CRC_W-1];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(input logic [OPC_W-1:0] op,
                                                     input logic [ARG_W-1:0] arg);
    logic [BODY_W-1:0] body;
    body = {2'b01, op, arg};
    return {body, crc7_body(body), 1'b1};
  endfunction
endpackage

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
  import sdcmd_pkg::*;
#(
  parameter int FW = FRAME_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             load,
  input  logic             abort,
  input  logic [OPC_W-1:0] opcode,
  input  logic [ARG_W-1:0] arg,
  output logic             line_o,
  output logic             line_oe,
  output logic             done
);
  localparam int CW = $clog2(FW);

  logic [FW-1:0] sr_q;
  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic          last_bit;

  assign last_bit = (cnt_q == CW'(FW - 1));
  assign done     = act_q && clk_en && last_bit && !abort && !load;
  assign line_o   = act_q ? sr_q[FW-1] : 1'b1;
  assign line_oe  = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '1;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load) begin
      sr_q  <= build_frame(opcode, arg);
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (abort) begin
      act_q <= 1'b0;
    end else if (act_q && clk_en) begin
      sr_q <= {sr_q[FW-2:0], 1'b1};
      if (last_bit) act_q <= 1'b0;
      else          cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_START_BIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> !line_o); // R1
  AST_END_BIT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> line_o); // R1
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe && !clk_en && !load && !abort) |=> ($stable(line_o) && line_oe)); // R9
endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
  import sdcmd_pkg::*;
#(
  parameter int TMO = 64,
  parameter int SW  = FRAME_W,
  parameter int LW  = LONG_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clk_en,
  input  logic                              start,
  input  logic                              abort,
  input  logic                              long_i,
  input  logic                              line_i,
  output logic                              done,
  output logic                              tmo,
  output logic                              crc_bad,
  output logic [RSP_WORDS-1:0][WORD_W-1:0]  rsp
);
  localparam int WC_W  = (TMO > 1) ? $clog2(TMO) : 1;
  localparam int BC_W  = $clog2(LW);
  localparam int PAY_W = RSP_WORDS * WORD_W;

  typedef enum logic [1:0] {RX_OFF, RX_WAIT, RX_BITS} rx_state_t;

  rx_state_t      st_q;
  logic [WC_W-1:0] wcnt_q;
  logic [BC_W-1:0] bcnt_q;
  logic [LW-1:0]   sr_q;
  logic [LW-1:0]   sr_nx;
  logic            long_q;
  logic [BC_W-1:0] lenm1;
  logic            see_start;
  logic            win_out;
  logic            fin;

  assign sr_nx     = {sr_q[LW-2:0], line_i};
  assign lenm1     = long_q ? BC_W'(LW - 1) : BC_W'(SW - 1);
  assign see_start = (st_q == RX_WAIT) && clk_en && !line_i && !abort;
  assign win_out   = (st_q == RX_WAIT) && clk_en && line_i && (wcnt_q == WC_W'(TMO - 1));
  assign fin       = (st_q == RX_BITS) && clk_en && (bcnt_q == lenm1);
  assign done      = fin && !abort;
  assign tmo       = win_out && !abort;
  assign crc_bad   = done && !long_q &&
                     (crc7_body(sr_nx[SW-1:CRC_W+1]) != sr_nx[CRC_W:1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_OFF;
      wcnt_q <= '0;
      bcnt_q <= '0;
      sr_q   <= '0;
      long_q <= 1'b0;
    end else if (abort) begin
      st_q <= RX_OFF;
    end else if (start) begin
      st_q   <= RX_WAIT;
      wcnt_q <= '0;
      bcnt_q <= '0;
      sr_q   <= '0;
      long_q <= long_i;
    end else if (clk_en) begin
      case (st_q)
        RX_WAIT: begin
          if (!line_i) begin
            st_q   <= RX_BITS;
            sr_q   <= sr_nx;
            bcnt_q <= BC_W'(1);
          end else if (win_out) begin
            st_q <= RX_OFF;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        RX_BITS: begin
          sr_q   <= sr_nx;
          bcnt_q <= bcnt_q + 1'b1;
          if (fin) st_q <= RX_OFF;
        end
        default: ;
      endcase
    end
  end

  for (genvar w = 0; w < RSP_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rsp[w] <= '0;
      end else if (done) begin
        if (long_q)
          rsp[w] <= sr_nx[PAY_W-1-WORD_W*w -: WORD_W];
        else if (w == 0)
          rsp[w] <= sr_nx[SW-1-HDR_W -: WORD_W];
      end
    end
  end

  AST_RSP_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(rsp)); // R3
  AST_START_ENTERS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    see_start |=> (st_q == RX_BITS)); // R4
  AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> (st_q == RX_OFF)); // R4
endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
  import sdcmd_pkg::*;
#(
  parameter int RSP_TMO = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              cmd_i,
  output logic              cmd_o,
  output logic              cmd_oe,
  output logic              busy,
  output logic [STAT_W-1:0] status,
  output logic [31:0]       resp0,
  output logic [31:0]       resp1,
  output logic [31:0]       resp2,
  output logic [31:0]       resp3
);
  seq_state_t               st_q;
  logic [ARG_W-1:0]         arg_q;
  logic                     rsp_exp_q;
  logic                     long_q;
  logic [STAT_W-1:0]        stat_q;
  logic [STAT_W-1:0]        set_mask;
  logic [STAT_W-1:0]        clr_mask;
  logic                     cmd_wr, go, abort, clr_wr;
  logic                     tx_done, rx_start, rx_done, rx_tmo, rx_crc_bad;
  logic [RSP_WORDS-1:0][WORD_W-1:0] rsp_w;

  assign cmd_wr   = wr_en && (wr_addr == ADR_CMD);
  assign go       = cmd_wr && wr_data[CMDB_EN];
  assign abort    = cmd_wr && !wr_data[CMDB_EN];
  assign clr_wr   = wr_en && (wr_addr == ADR_CLR);
  assign rx_start = tx_done && rsp_exp_q;

  sdcmd_tx #(.FW(FRAME_W)) tx_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .load(go), .abort(abort),
    .opcode(wr_data[OPC_W-1:0]), .arg(arg_q),
    .line_o(cmd_o), .line_oe(cmd_oe), .done(tx_done)
  );

  sdcmd_rx #(.TMO(RSP_TMO), .SW(FRAME_W), .LW(LONG_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .start(rx_start), .abort(cmd_wr), .long_i(long_q), .line_i(cmd_i),
    .done(rx_done), .tmo(rx_tmo), .crc_bad(rx_crc_bad), .rsp(rsp_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arg_q     <= '0;
      rsp_exp_q <= 1'b0;
      long_q    <= 1'b0;
      st_q      <= SEQ_IDLE;
    end else begin
      if (wr_en && (wr_addr == ADR_ARG)) arg_q <= wr_data;
      if (go) begin
        rsp_exp_q <= wr_data[CMDB_RESP];
        long_q    <= wr_data[CMDB_LONG];
        st_q      <= SEQ_TX;
      end else if (abort) begin
        st_q <= SEQ_IDLE;
      end else begin
        case (st_q)
          SEQ_TX:  if (tx_done) st_q <= rsp_exp_q ? SEQ_RX : SEQ_IDLE;
          SEQ_RX:  if (rx_done || rx_tmo) st_q <= SEQ_IDLE;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    set_mask              = '0;
    set_mask[ST_SENT]     = tx_done && !rsp_exp_q;
    set_mask[ST_RSPEND]   = rx_done && !rx_crc_bad;
    set_mask[ST_CRCFAIL]  = rx_crc_bad;
    set_mask[ST_TIMEOUT]  = rx_tmo;
    clr_mask              = clr_wr ? wr_data[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_mask) | set_mask;
  end

  assign busy   = (st_q != SEQ_IDLE);
  assign status = stat_q;
  assign resp0  = rsp_w[0];
  assign resp1  = rsp_w[1];
  assign resp2  = rsp_w[2];
  assign resp3  = rsp_w[3];

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !cmd_oe)); // R6
  AST_SENT_WITHOUT_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !rsp_exp_q) |=> stat_q[ST_SENT]); // R2
  AST_REPLY_NOT_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start |=> (busy && !cmd_oe)); // R2
  AST_TIMEOUT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tmo |=> (stat_q[ST_TIMEOUT] && !busy)); // R4

  for (genvar b = 0; b < STAT_W; b++) begin : g_sticky
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[b] && !(clr_wr && wr_data[b])) |=> stat_q[b]); // R7
  end
endmodule

// File: tb/sdcmd_seq_tb_top.sv
`timescale 1ns/1ps
module sdcmd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        cmd_i = 1'b1;
  logic        cmd_o, cmd_oe, busy;
  logic [3:0]  status;
  logic [31:0] resp0, resp1, resp2, resp3;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1357_9bdf;

  always #2.5 clk = ~clk;

  sdcmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmd_i(cmd_i), .cmd_o(cmd_o), .cmd_oe(cmd_oe), .busy(busy),
    .status(status), .resp0(resp0), .resp1(resp1), .resp2(resp2), .resp3(resp3)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  // remainder of body*x^7 divided by x^7+x^3+1
  function automatic logic [6:0] div_crc(input logic [39:0] d);
    logic [46:0] v;
    v = {d, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (v[i]) v[i -: 8] = v[i -: 8] ^ 8'h89;
    return v[6:0];
  endfunction

  function automatic logic [47:0] exp_frame(input logic [5:0] op, input logic [31:0] arg);
    return {2'b01, op, arg, div_crc({2'b01, op, arg}), 1'b1};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick(input logic b, input logic dw, input logic [1:0] a,
                      input logic [31:0] d, output logic line);
    @(negedge clk);
    cmd_i = b; clk_en = 1'b1; line = cmd_o;
    if (dw) begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
    @(negedge clk); clk_en = 1'b0; wr_en = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic idle_ticks(input int n, input logic b);
    logic l;
    for (int i = 0; i < n; i++) tick(b, 1'b0, 2'd0, 32'd0, l);
  endtask

  // issue a command and collect its frame; an optional write rides the last strobe
  task automatic send(input logic [5:0] op, input logic [31:0] arg, input logic rsp,
                      input logic lng, input logic lw, input logic [1:0] la,
                      input logic [31:0] ld, input string tag);
    logic [47:0] got;
    logic l;
    wr(2'd0, arg);
    wr(2'd1, {23'b0, 1'b1, lng, rsp, op});
    for (int k = 0; k < 48; k++) begin
      tick(1'b1, (k == 47) && lw, la, ld, l);
      got[47-k] = l;
    end
    chk({tag, " R1 frame"}, got, exp_frame(op, arg));
  endtask

  task automatic reply(input int d, input logic [135:0] bits, input int n);
    logic l;
    idle_ticks(d, 1'b1);
    for (int i = n - 1; i >= 0; i--) tick(bits[i], 1'b0, 2'd0, 32'd0, l);
    cmd_i = 1'b1;
  endtask

  function automatic logic [47:0] short_rsp(input logic [5:0] op, input logic [31:0] p,
                                            input logic bad);
    logic [6:0] c;
    c = div_crc({2'b00, op, p}) ^ {6'b0, bad};
    return {2'b00, op, p, c, 1'b1};
  endfunction

  initial begin : watchdog
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] a, p;
    logic [127:0] lp;
    logic l;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset status", status, 4'h0);
    chk("R1 reset line", {busy, cmd_oe, cmd_o}, 3'b001);

    // R1 R2: every opcode, no response
    for (int op = 0; op < 64; op++) begin
      seed = nxt(seed); a = seed;
      send(6'(op), a, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0, "sweep");
      chk("R2 sent flag", status, 4'b1000);
      chk("R1 line released", {busy, cmd_oe}, 2'b00);
      wr(2'd2, 32'hF);
      chk("R7 clear all", status, 4'h0);
    end

    // R9: no strobes, no motion
    wr(2'd0, 32'hA5A5_0F0F);
    wr(2'd1, 32'h0000_0105);
    repeat (20) @(negedge clk);
    chk("R9 held without strobe", {busy, cmd_oe, cmd_o}, 3'b110);
    wr(2'd1, 32'h0);
    chk("R6 abort idle", {busy, cmd_oe}, 2'b00);

    // R3 R2 R5: short replies with good CRC
    for (int i = 0; i < 8; i++) begin
      seed = nxt(seed); p = seed;
      send(6'(i * 7), p ^ 32'h5555, 1'b1, 1'b0, 1'b0, 2'd0, 32'd0, "short");
      chk("R2 no sent for reply", status[3], 1'b0);
      reply(2 + i * 8, {88'b0, short_rsp(6'(i * 7), p, 1'b0)}, 48);
      chk("R3 short resp0", resp0, p);
      chk("R2 response end", status, 4'b0100);
      wr(2'd2, 32'hF);
    end

    // R5: bad CRC on short reply
    send(6'd13, 32'h1, 1'b1, 1'b0, 1'b0, 2'd0, 32'd0, "badcrc");
    reply(4, {88'b0, short_rsp(6'd13, 32'hCAFE_F00D, 1'b1)}, 48);
    chk("R5 crc fail only", status, 4'b0001);
    chk("R3 resp0 still captured", resp0, 32'hCAFE_F00D);
    wr(2'd2, 32'hF);

    // R3 R5: long replies, CRC never judged
    for (int i = 0; i < 3; i++) begin
      for (int w = 0; w < 4; w++) begin seed = nxt(seed); lp[127-32*w -: 32] = seed; end
      send(6'd2, 32'h0, 1'b1, 1'b1, 1'b0, 2'd0, 32'd0, "long");
      reply(3 + i, {2'b00, 6'h3F, lp}, 136);
      chk("R3 long words", {resp0, resp1, resp2, resp3}, lp);
      chk("R5 long no crc fail", status, 4'b0100);
      wr(2'd2, 32'hF);
    end

    // R3: short reply leaves words 1..3
    send(6'd9, 32'h0, 1'b1, 1'b0, 1'b0, 2'd0, 32'd0, "short2");
    reply(2, {88'b0, short_rsp(6'd9, 32'h0BAD_BEEF, 1'b0)}, 48);
    chk("R3 upper words kept", {resp1, resp2, resp3}, lp[95:0]);
    chk("R3 short word0", resp0, 32'h0BAD_BEEF);
    wr(2'd2, 32'hF);

    // R4: window boundary
    send(6'd7, 32'h7, 1'b1, 1'b0, 1'b0, 2'd0, 32'd0, "win63");
    reply(63, {88'b0, short_rsp(6'd7, 32'h1234_5678, 1'b0)}, 48);
    chk("R4 start at strobe 64 accepted", status, 4'b0100);
    wr(2'd2, 32'hF);
    send(6'd7, 32'h7, 1'b1, 1'b0, 1'b0, 2'd0, 32'd0, "tmo");
    idle_ticks(63, 1'b1);
    chk("R4 still waiting", {busy, status}, 5'b1_0000);
    idle_ticks(1, 1'b1);
    chk("R4 timeout", {busy, status}, 5'b0_0010);

    // R7: partial clear
    send(6'd1, 32'h1, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0, "sticky");
    idle_ticks(5, 1'b1);
    chk("R7 flags accumulate", status, 4'b1010);
    wr(2'd2, 32'h2);
    chk("R7 partial clear", status, 4'b1000);
    wr(2'd2, 32'hF);

    // R6: abort mid frame, then stray line activity
    wr(2'd0, 32'hFFFF_0000);
    wr(2'd1, 32'h0000_0140);
    idle_ticks(10, 1'b1);
    wr(2'd1, 32'h0);
    chk("R6 abort mid frame", {busy, cmd_oe, cmd_o}, 3'b001);
    idle_ticks(60, 1'b0);
    chk("R6 no flag after abort", status, 4'h0);

    // R6: abort while waiting for reply
    send(6'd3, 32'h3, 1'b1, 1'b0, 1'b0, 2'd0, 32'd0, "abwait");
    wr(2'd1, 32'h0);
    reply(1, {88'b0, short_rsp(6'd3, 32'h1, 1'b0)}, 48);
    chk("R6 reply ignored", {busy, status}, 5'b0_0000);
    idle_ticks(70, 1'b1);
    chk("R6 no timeout after abort", status, 4'h0);

    // R8: clear lands on the completing strobe
    send(6'd4, 32'h4, 1'b0, 1'b0, 1'b1, 2'd2, 32'hF, "setwin");
    chk("R8 set beats clear", status, 4'b1000);
    wr(2'd2, 32'hF);

    // R6: abort lands on the completing strobe
    send(6'd5, 32'h5, 1'b0, 1'b0, 1'b1, 2'd1, 32'h0, "abtlast");
    chk("R6 abort on last strobe", {busy, status}, 5'b0_0000);

    l = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors + int'(l));
    $finish;
  end
endmodule